// File: doc/BRIEF.md
# Zero-Flag Branch and Loop Sequencer

This block produces the program counter of a small processor. In each clock cycle it takes one decoded instruction class, a signed branch displacement and the Zero flag that the ALU produced for the preceding operation. It then loads the program counter with the next instruction address. Equality tests work by having the ALU subtract one operand from the other. The two conditional branches then read the same Zero flag through a single gate: an exclusive-OR with a polarity bit picks between branch-on-zero and branch-on-nonzero. A skip instruction adds one extra step to the counter when the flag is set.

The block also holds a count register for counted loops. The loop instruction decrements the count and tests the new value, not the old one. It jumps back while the new value is non-zero, so the loop ends on the pass that starts with a count of one. Software sets the count through a load strobe.

The block has no state machine. Its state is two registers: the program counter and the loop count. A selector picks one of three next-address sources: sequential (PC+1), skip (PC+2) or target (PC+1+displacement). The instruction class and the flags decide which source is used.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst_n` is low, the program counter and the loop count are cleared to 0.
- R2: Class codes 0, 5, 6 and 7 are plain instructions. They load PC+1 and hold `taken_out` at 0.
- R3: Class code 1 branches when `zero_in` is 1. The target is PC+1 plus the sign-extended `offset`, modulo 2^PC_W. `taken_out` shows the decision in the same cycle.
- R4: Class code 2 branches to the same target when `zero_in` is 0 and otherwise loads PC+1. It uses the same XOR-gated decision as R3 with the polarity inverted.
- R5: Class code 3 loads PC+2 when `zero_in` is 1 and PC+1 when it is 0. `taken_out` stays 0.
- R6: Class code 4 writes count−1 into the loop count. It branches to the R3 target exactly when count−1 is non-zero, and otherwise loads PC+1.
- R7: A loop instruction that starts with a count of 1 leaves a count of 0 and falls through to PC+1.
- R8: A loop instruction that starts with a count of 0 wraps the count to all ones and branches.
- R9: The loop count keeps its value in any cycle with neither a loop instruction nor a load strobe.
- R10: When `cnt_load` is high, the count takes `cnt_load_val` on the next edge, even if a loop instruction is present in the same cycle. The PC decision in that cycle still uses the old count minus one.
- R11: `zero_in` has no effect on loop and plain instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_class | input | 3 | Decoded class of the instruction at the current PC |
| offset | input | OFF_W | Signed branch displacement in instruction words |
| zero_in | input | 1 | Zero flag from the preceding ALU operation |
| cnt_load | input | 1 | Strobe that writes the loop count |
| cnt_load_val | input | CNT_W | Value written by the strobe |
| pc_out | output | PC_W | Current program counter |
| cnt_out | output | CNT_W | Current loop count |
| taken_out | output | 1 | High when the branch target is selected this cycle |

## Verification
Two cases are the hardest to reach from the ports. The first is a loop instruction that arrives in the same cycle as a load strobe, where the branch uses the old count while the register takes the new value. The second is a loop that starts from a count of zero. The stimulus reaches both by first using the load port to place chosen counts (3, 1, 0) in the register and then issuing loop instructions back to back. In separate steps it issues a load and a loop in the same cycle. The reference model tracks the PC and the count in plain integers and compares them after every edge.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
    typedef enum logic [2:0] {
        CLS_PLAIN = 3'd0,
        CLS_BEQ   = 3'd1,
        CLS_BNE   = 3'd2,
        CLS_SKZ   = 3'd3,
        CLS_LOOP  = 3'd4,
        CLS_RSV5  = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } instr_cls_e;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_SKIP   = 2'd1,
        NXT_TARGET = 2'd2
    } next_sel_e;
endpackage

// File: rtl/fbu_decide.sv
module fbu_decide
    import fbu_pkg::*;
(
    input  instr_cls_e cls,
    input  logic       zero_in,
    input  logic       loop_nonzero,
    output next_sel_e  sel,
    output logic       taken
);
    logic is_cond;
    logic polarity;
    logic cond_taken;

    always_comb begin
        is_cond    = (cls == CLS_BEQ) || (cls == CLS_BNE);
        polarity   = (cls == CLS_BNE);
        cond_taken = is_cond & (zero_in ^ polarity);
        unique case (cls)
            CLS_BEQ, CLS_BNE: sel = cond_taken ? NXT_TARGET : NXT_SEQ;
            CLS_SKZ:          sel = zero_in ? NXT_SKIP : NXT_SEQ;
            CLS_LOOP:         sel = loop_nonzero ? NXT_TARGET : NXT_SEQ;
            default:          sel = NXT_SEQ;
        endcase
        taken = (sel == NXT_TARGET);
    end
endmodule

// File: rtl/fbu_loop_count.sv
module fbu_loop_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_exec,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             dec_nonzero
);
    logic [CNT_W-1:0] dec_val;

    always_comb begin
        dec_val     = cnt_q - CNT_W'(1);
        dec_nonzero = |dec_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_en)
            cnt_q <= load_val;
        else if (loop_exec)
            cnt_q <= dec_val;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !loop_exec) |=> $stable(cnt_q));
    assert_load_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q == $past(load_val)));
    assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_exec && !load_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/fbu_target.sv
module fbu_target
    import fbu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  next_sel_e        sel,
    output logic [PC_W-1:0]  next_pc
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] pc_seq;

    always_comb begin
        disp   = {{EXT_W{offset[OFF_W-1]}}, offset};
        pc_seq = pc + PC_W'(1);
        unique case (sel)
            NXT_SKIP:   next_pc = pc + PC_W'(2);
            NXT_TARGET: next_pc = pc_seq + disp;
            default:    next_pc = pc_seq;
        endcase
    end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fbu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       instr_class,
    input  logic [OFF_W-1:0] offset,
    input  logic             zero_in,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic [PC_W-1:0]  pc_out,
    output logic [CNT_W-1:0] cnt_out,
    output logic             taken_out
);
    instr_cls_e      cls;
    next_sel_e       sel;
    logic            loop_nonzero;
    logic            taken;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;
    logic [CNT_W-1:0] cnt_q;

    assign cls = instr_cls_e'(instr_class);

    fbu_loop_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_exec   (cls == CLS_LOOP),
        .load_en     (cnt_load),
        .load_val    (cnt_load_val),
        .cnt_q       (cnt_q),
        .dec_nonzero (loop_nonzero)
    );

    fbu_decide u_decide (
        .cls          (cls),
        .zero_in      (zero_in),
        .loop_nonzero (loop_nonzero),
        .sel          (sel),
        .taken        (taken)
    );

    fbu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc      (pc_q),
        .offset  (offset),
        .sel     (sel),
        .next_pc (next_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= next_pc;
    end

    always_comb begin
        pc_out    = pc_q;
        cnt_out   = cnt_q;
        taken_out = taken;
    end

    assert_plain_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd0 || instr_class >= 3'd5) |=> (pc_out == $past(pc_out) + PC_W'(1)));
    assert_beq_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd1) |-> (taken_out == zero_in));
    assert_bne_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd2) |-> (taken_out == !zero_in));
    assert_skip_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd3 && zero_in) |=> (pc_out == $past(pc_out) + PC_W'(2)));
    assert_exit_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd4 && !cnt_load && cnt_out == CNT_W'(1))
            |=> (cnt_out == '0 && pc_out == $past(pc_out) + PC_W'(1)));
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_class == 3'd4 && cnt_out == '0) |-> taken_out);
endmodule

// File: tb/flag_branch_unit_test.sv
module flag_branch_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  instr_class = 3'd0;
    logic [7:0]  offset = 8'd0;
    logic        zero_in = 1'b0;
    logic        cnt_load = 1'b0;
    logic [7:0]  cnt_load_val = 8'd0;
    logic [15:0] pc_out;
    logic [7:0]  cnt_out;
    logic        taken_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] ref_pc = 16'd0;
    logic [7:0]  ref_cnt = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_class(instr_class), .offset(offset),
        .zero_in(zero_in), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .pc_out(pc_out), .cnt_out(cnt_out), .taken_out(taken_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [7:0] off, input logic z,
                        input logic ld, input logic [7:0] lv, input string tag);
        logic [15:0] tgt;
        logic [15:0] exp_pc;
        logic [7:0]  dec;
        logic [7:0]  exp_cnt;
        logic        exp_tk;
        instr_class = c; offset = off; zero_in = z; cnt_load = ld; cnt_load_val = lv;
        dec = ref_cnt - 8'd1;
        tgt = ref_pc + 16'd1 + {{8{off[7]}}, off};
        case (c)
            3'd1:    exp_tk = z;
            3'd2:    exp_tk = !z;
            3'd4:    exp_tk = (dec != 8'd0);
            default: exp_tk = 1'b0;
        endcase
        if (exp_tk)             exp_pc = tgt;
        else if (c == 3'd3 && z) exp_pc = ref_pc + 16'd2;
        else                    exp_pc = ref_pc + 16'd1;
        exp_cnt = ld ? lv : ((c == 3'd4) ? dec : ref_cnt);
        #1;
        check({tag, " taken"}, int'(taken_out), int'(exp_tk));
        @(posedge clk);
        @(negedge clk);
        check({tag, " pc"}, int'(pc_out), int'(exp_pc));
        check({tag, " cnt"}, int'(cnt_out), int'(exp_cnt));
        ref_pc = exp_pc;
        ref_cnt = exp_cnt;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pc", int'(pc_out), 0);
        check("R1 reset cnt", int'(cnt_out), 0);
        rst_n = 1'b1;
        // R2 plain classes, R11 zero ignored
        step(3'd0, 8'd9, 1'b0, 1'b0, 8'd0, "R2 plain");
        step(3'd0, 8'd9, 1'b1, 1'b0, 8'd0, "R11 plain zero");
        step(3'd5, 8'd3, 1'b1, 1'b0, 8'd0, "R2 code5");
        step(3'd6, 8'd3, 1'b0, 1'b0, 8'd0, "R2 code6");
        step(3'd7, 8'd3, 1'b1, 1'b0, 8'd0, "R2 code7");
        // R3 branch on zero
        step(3'd1, 8'd10, 1'b1, 1'b0, 8'd0, "R3 beq taken");
        step(3'd1, 8'd10, 1'b0, 1'b0, 8'd0, "R3 beq not");
        step(3'd1, 8'hF8, 1'b1, 1'b0, 8'd0, "R3 beq negative");
        // R4 branch on nonzero
        step(3'd2, 8'hFC, 1'b0, 1'b0, 8'd0, "R4 bne taken");
        step(3'd2, 8'd20, 1'b1, 1'b0, 8'd0, "R4 bne not");
        // R5 skip
        step(3'd3, 8'd50, 1'b1, 1'b0, 8'd0, "R5 skip set");
        step(3'd3, 8'd50, 1'b0, 1'b0, 8'd0, "R5 skip clear");
        // R9 hold, load then loop
        step(3'd0, 8'd0, 1'b0, 1'b1, 8'd3, "R10 load");
        step(3'd0, 8'd0, 1'b0, 1'b0, 8'd0, "R9 hold");
        step(3'd4, 8'hFE, 1'b0, 1'b0, 8'd0, "R6 loop pass1");
        step(3'd4, 8'hFE, 1'b1, 1'b0, 8'd0, "R11 loop pass2 zero");
        step(3'd4, 8'hFE, 1'b0, 1'b0, 8'd0, "R7 loop exit");
        // R8 wrap from zero
        step(3'd4, 8'd4, 1'b1, 1'b0, 8'd0, "R8 loop wrap");
        step(3'd2, 8'd1, 1'b1, 1'b0, 8'd0, "R9 hold after wrap");
        // R10 load with loop same cycle
        step(3'd4, 8'd6, 1'b0, 1'b1, 8'd1, "R10 load beats loop");
        step(3'd4, 8'd6, 1'b0, 1'b1, 8'd7, "R10 count1 load");
        step(3'd4, 8'h80, 1'b0, 1'b0, 8'd0, "R6 loop far back");
        // R1 reset again mid-run
        rst_n = 1'b0;
        instr_class = 3'd0; cnt_load = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rereset pc", int'(pc_out), 0);
        check("R1 rereset cnt", int'(cnt_out), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule